// File: doc/BRIEF.md
# Ring Tail Result Collector

This block sits at the far end of an open, one-way ring of compute nodes. Every clock cycle the ring hands it one word together with a 3-bit type tag. The collector passes over empty words. It also passes over the command words that the head of the ring sent out to load jobs into the nodes.

The collector keeps the result words that the nodes insert. It rebuilds each four-word result into a single buffer entry. The entry holds four fields: node address, result value, and the two halves of the node's cycle counter. The host reads entries later through a pop interface. The batch marker word travels down the ring behind every node's results. When it reaches the collector, a done flag is raised. This tells the host that the batch has fully drained.

Two sticky flags record lost results:
- one for a result sequence that breaks the fixed word order;
- one for a complete result that found the buffer full.

Top module: `ring_tail_collector`

## Requirements
- R1: While reset is high and in the cycle after it, `res_level` is 0 and `batch_done`, `proto_err`, `overflow` and `res_valid` are all 0.
- R2: Words tagged 000 (empty), 010 (job address) or 011 (job value) are never stored. They do not advance or break a result packet that is being collected.
- R3: Result words carry tags 100 (address), 101 (result value), 110 (counter low half) and 111 (counter high half), and must arrive in that order. A packet is written to the buffer only when its 111 word is received. `res_level` rises two cycles after the edge that samples that word.
- R4: A `host_pop` sampled while `res_level` is nonzero produces `res_valid` high in the next cycle. `res_addr`, `res_xres` and `res_cycles` (high half in bits [2W-1:W]) then hold the oldest entry, in arrival order. A pop sampled while the buffer is empty yields `res_valid` low.
- R5: A word tagged 001 sets `batch_done` one cycle after it is sampled. The flag stays high until cleared.
- R6: A result word whose tag is not the next one expected drops the partial packet and is itself dropped. The next packet is expected to start with tag 100. One cycle later, the sticky `proto_err` flag is set.
- R7: A packet that completes while the buffer already holds DEPTH entries is dropped, even if a pop is taken in the same cycle. The sticky `overflow` flag is set in the same cycle the packet would have been counted.
- R8: `host_clear` clears `batch_done`, `proto_err` and `overflow`. A flag that is being set in the same cycle stays set.
- R9: `res_level` equals the number of stored, unread entries and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_tag | input | 3 | Type tag of the current ring word |
| ring_data | input | DATA_W | Payload of the current ring word |
| host_pop | input | 1 | Request to read the oldest entry |
| host_clear | input | 1 | Clear the done, protocol-error and overflow flags |
| res_valid | output | 1 | Read data valid, one cycle after an accepted pop |
| res_addr | output | DATA_W | Node address of the read entry |
| res_xres | output | DATA_W | Result value of the read entry |
| res_cycles | output | 2*DATA_W | Cycle count of the read entry |
| res_level | output | $clog2(DEPTH+1) | Number of unread entries |
| batch_done | output | 1 | Batch marker has arrived |
| proto_err | output | 1 | Sticky: result words arrived out of order |
| overflow | output | 1 | Sticky: a completed packet was dropped because the buffer was full |

## Verification
The bench builds the collector with DATA_W = 8 and DEPTH = 4. The small depth lets five back-to-back packets reach the full buffer. This exercises both the plain overflow drop and the case where a commit and a pop land in the same full cycle. The 8-bit fields give every packet distinct, recognisable values, so ordering errors in the read-out show up at once. Job and empty words are injected in the middle of packets. Broken sequences are also sent, to show that a break costs only the partial packet.

// File: rtl/ring_tail_pkg.sv
package ring_tail_pkg;

  typedef enum logic [2:0] {
    TAG_EMPTY = 3'b000,
    TAG_TOKEN = 3'b001,
    TAG_JADDR = 3'b010,
    TAG_JVAL  = 3'b011,
    TAG_RADDR = 3'b100,
    TAG_RXRES = 3'b101,
    TAG_RCLO  = 3'b110,
    TAG_RCHI  = 3'b111
  } ring_tag_e;

endpackage

// File: rtl/ring_tail_assembler.sv
module ring_tail_assembler #(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            tag,
  input  logic [DATA_W-1:0]     data,
  output logic                  commit_vld,
  output logic [4*DATA_W-1:0]   commit_word,
  output logic                  seq_err
);

  // Result tags have the top bit set; the low two bits give the word's slot.
  logic              is_result;
  logic [1:0]        slot;
  logic [1:0]        stage;
  logic              in_order;
  logic [DATA_W-1:0] fld [3];

  assign is_result = tag[2];
  assign slot      = tag[1:0];
  assign in_order  = is_result && (slot == stage);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage      <= 2'd0;
      commit_vld <= 1'b0;
      seq_err    <= 1'b0;
    end else begin
      commit_vld <= 1'b0;
      seq_err    <= 1'b0;
      if (in_order) begin
        if (stage == 2'd3) begin
          commit_vld <= 1'b1;
          stage      <= 2'd0;
        end else begin
          stage <= stage + 2'd1;
        end
      end else if (is_result) begin
        seq_err <= 1'b1;
        stage   <= 2'd0;
      end
    end
  end

  // Field holding registers, one per leading word of the packet.
  for (genvar i = 0; i < 3; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (in_order && stage == 2'(i)) fld[i] <= data;
    end
  end

  // Entry layout: {address, result, counter high, counter low}.
  always_ff @(posedge clk) begin
    if (in_order && stage == 2'd3) commit_word <= {fld[0], fld[1], data, fld[2]};
  end

endmodule

// File: rtl/ring_tail_fifo.sv
module ring_tail_fifo #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word,
  output logic [CNT_W-1:0]  count,
  output logic              drop
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              is_full, is_empty, do_wr, do_rd;

  assign is_full  = (count == CNT_W'(DEPTH));
  assign is_empty = (count == '0);
  assign do_wr    = wr_en && !is_full;
  assign do_rd    = rd_en && !is_empty;
  assign drop     = wr_en && is_full;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_word <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_wr) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (do_wr && !do_rd)      count <= count + 1'b1;
      else if (do_rd && !do_wr) count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/ring_tail_flags.sv
module ring_tail_flags (
  input  logic clk,
  input  logic rst,
  input  logic token_seen,
  input  logic seq_err,
  input  logic drop,
  input  logic clear,
  output logic done,
  output logic perr,
  output logic ovf
);

  // Setting always wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      perr <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (token_seen) done <= 1'b1;
      else if (clear) done <= 1'b0;
      if (seq_err)    perr <= 1'b1;
      else if (clear) perr <= 1'b0;
      if (drop)       ovf  <= 1'b1;
      else if (clear) ovf  <= 1'b0;
    end
  end

endmodule

// File: rtl/ring_tail_collector.sv
module ring_tail_collector
  import ring_tail_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 ring_tag,
  input  logic [DATA_W-1:0]          ring_data,
  input  logic                       host_pop,
  input  logic                       host_clear,
  output logic                       res_valid,
  output logic [DATA_W-1:0]          res_addr,
  output logic [DATA_W-1:0]          res_xres,
  output logic [2*DATA_W-1:0]        res_cycles,
  output logic [$clog2(DEPTH+1)-1:0] res_level,
  output logic                       batch_done,
  output logic                       proto_err,
  output logic                       overflow
);

  localparam int ENTRY_W = 4 * DATA_W;

  logic               commit_vld, seq_err, drop;
  logic [ENTRY_W-1:0] commit_word, rd_word;

  ring_tail_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk         (clk),
    .rst         (rst),
    .tag         (ring_tag),
    .data        (ring_data),
    .commit_vld  (commit_vld),
    .commit_word (commit_word),
    .seq_err     (seq_err)
  );

  ring_tail_fifo #(.WORD_W(ENTRY_W), .DEPTH(DEPTH)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (commit_vld),
    .wr_word  (commit_word),
    .rd_en    (host_pop),
    .rd_valid (res_valid),
    .rd_word  (rd_word),
    .count    (res_level),
    .drop     (drop)
  );

  ring_tail_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .token_seen (ring_tag == TAG_TOKEN),
    .seq_err    (seq_err),
    .drop       (drop),
    .clear      (host_clear),
    .done       (batch_done),
    .perr       (proto_err),
    .ovf        (overflow)
  );

  assign res_addr   = rd_word[4*DATA_W-1:3*DATA_W];
  assign res_xres   = rd_word[3*DATA_W-1:2*DATA_W];
  assign res_cycles = rd_word[2*DATA_W-1:0];

endmodule

// File: rtl/ring_tail_checker.sv
module ring_tail_checker
  import ring_tail_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       ring_tag,
  input logic             host_pop,
  input logic             host_clear,
  input logic             res_valid,
  input logic [CNT_W-1:0] res_level,
  input logic             batch_done,
  input logic             proto_err,
  input logic             overflow
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (res_level == '0 && !batch_done && !proto_err && !overflow && !res_valid));

  // R5
  token_done_chk: assert property (@(posedge clk) disable iff (rst)
    (ring_tag == TAG_TOKEN) |=> batch_done);

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (batch_done && !host_clear) |=> batch_done);

  // R4
  pop_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (host_pop && res_level != '0) |=> res_valid);

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (host_pop && res_level == '0) |=> !res_valid);

  // R6
  proto_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (proto_err && !host_clear) |=> proto_err);

  // R7
  no_overflow_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !host_clear) |=> overflow);

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    res_level <= CNT_W'(DEPTH));

endmodule

bind ring_tail_collector ring_tail_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ring_tag   (ring_tag),
  .host_pop   (host_pop),
  .host_clear (host_clear),
  .res_valid  (res_valid),
  .res_level  (res_level),
  .batch_done (batch_done),
  .proto_err  (proto_err),
  .overflow   (overflow)
);

// File: tb/ring_tail_collector_test.sv
`timescale 1ns/1ps
module ring_tail_collector_test;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        ring_tag = 3'b000;
  logic [DATA_W-1:0] ring_data = '0;
  logic              host_pop = 1'b0;
  logic              host_clear = 1'b0;
  logic              res_valid;
  logic [DATA_W-1:0] res_addr, res_xres;
  logic [2*DATA_W-1:0] res_cycles;
  logic [CNT_W-1:0]  res_level;
  logic              batch_done, proto_err, overflow;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  ring_tail_collector #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .ring_tag(ring_tag), .ring_data(ring_data),
    .host_pop(host_pop), .host_clear(host_clear), .res_valid(res_valid),
    .res_addr(res_addr), .res_xres(res_xres), .res_cycles(res_cycles),
    .res_level(res_level), .batch_done(batch_done), .proto_err(proto_err),
    .overflow(overflow)
  );

  // Behavioural reference model, updated on every rising edge.
  int          m_stage;
  logic [7:0]  m_f [3];
  bit          m_pend, m_errp, m_done, m_perr, m_ovf, m_rv;
  logic [31:0] m_pword, m_rw;
  logic [31:0] q [$];

  always @(posedge clk) begin
    if (rst) begin
      m_stage = 0; m_pend = 0; m_errp = 0; m_done = 0; m_perr = 0;
      m_ovf = 0; m_rv = 0; q.delete();
    end else begin
      int  old_size;
      bit  ovf_set;
      old_size = q.size();
      ovf_set  = 0;
      if (host_pop && old_size > 0) begin m_rw = q.pop_front(); m_rv = 1; end
      else m_rv = 0;
      if (m_pend) begin
        if (old_size < DEPTH) q.push_back(m_pword);
        else ovf_set = 1;
      end
      if (ring_tag == 3'b001) m_done = 1; else if (host_clear) m_done = 0;
      if (m_errp) m_perr = 1; else if (host_clear) m_perr = 0;
      if (ovf_set) m_ovf = 1; else if (host_clear) m_ovf = 0;
      m_pend = 0;
      m_errp = 0;
      if (ring_tag[2]) begin
        if (int'(ring_tag[1:0]) == m_stage) begin
          if (m_stage == 3) begin
            m_pend  = 1;
            m_pword = {m_f[0], m_f[1], ring_data, m_f[2]};
            m_stage = 0;
          end else begin
            m_f[m_stage] = ring_data;
            m_stage = m_stage + 1;
          end
        end else begin
          m_errp  = 1;
          m_stage = 0;
        end
      end
    end
  end

  task automatic cmp(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s (%s) %s: actual=%0h expected=%0h at %0t", req, cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("R9", "res_level", res_level, q.size());
    cmp("R5", "batch_done", batch_done, m_done);
    cmp("R6", "proto_err", proto_err, m_perr);
    cmp("R7", "overflow", overflow, m_ovf);
    cmp("R4", "res_valid", res_valid, m_rv);
    if (m_rv && res_valid)
      cmp("R4", "entry", {res_addr, res_xres, res_cycles}, m_rw);
  endtask

  // One cycle: check at the falling edge, then drive the next inputs.
  task automatic step(logic [2:0] tg, logic [7:0] d, logic pop, logic clr);
    @(negedge clk);
    compare_all();
    ring_tag = tg; ring_data = d; host_pop = pop; host_clear = clr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(3'b000, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic send_pkt(logic [7:0] a, logic [7:0] x, logic [15:0] c, logic pop);
    step(3'b100, a, pop, 1'b0);
    step(3'b101, x, 1'b0, 1'b0);
    step(3'b110, c[7:0], 1'b0, 1'b0);
    step(3'b111, c[15:8], 1'b0, 1'b0);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    compare_all();
    rst = 1'b0;
    idle(3);

    cur_req = "R3";
    send_pkt(8'h11, 8'hA1, 16'h1234, 1'b0);
    idle(3);
    cur_req = "R4";
    step(3'b000, 8'h00, 1'b1, 1'b0);
    idle(2);
    step(3'b000, 8'h00, 1'b1, 1'b0);   // pop on empty
    idle(2);

    cur_req = "R2";
    step(3'b010, 8'h55, 1'b0, 1'b0);
    step(3'b011, 8'h66, 1'b0, 1'b0);
    step(3'b100, 8'h22, 1'b0, 1'b0);
    step(3'b010, 8'h77, 1'b0, 1'b0);
    step(3'b101, 8'hB2, 1'b0, 1'b0);
    step(3'b000, 8'h99, 1'b0, 1'b0);
    step(3'b011, 8'h88, 1'b0, 1'b0);
    step(3'b110, 8'h34, 1'b0, 1'b0);
    step(3'b000, 8'h00, 1'b0, 1'b0);
    step(3'b111, 8'h56, 1'b0, 1'b0);
    idle(3);
    step(3'b000, 8'h00, 1'b1, 1'b0);
    idle(2);

    cur_req = "R6";
    step(3'b100, 8'h33, 1'b0, 1'b0);
    step(3'b101, 8'hC3, 1'b0, 1'b0);
    step(3'b111, 8'h99, 1'b0, 1'b0);   // skips the low half
    step(3'b110, 8'h01, 1'b0, 1'b0);   // no packet open
    idle(2);
    send_pkt(8'h44, 8'hD4, 16'hBEEF, 1'b0);
    idle(3);
    step(3'b000, 8'h00, 1'b1, 1'b0);
    idle(2);
    cur_req = "R8";
    step(3'b000, 8'h00, 1'b0, 1'b1);
    idle(2);

    cur_req = "R5";
    step(3'b001, 8'h00, 1'b0, 1'b0);
    idle(4);
    step(3'b001, 8'h00, 1'b0, 1'b1);   // set wins over clear
    idle(2);
    cur_req = "R8";
    step(3'b000, 8'h00, 1'b0, 1'b1);
    idle(2);

    cur_req = "R7";
    for (int k = 0; k < 5; k++)
      send_pkt(8'h50 + 8'(k), 8'hE0 + 8'(k), 16'h0100 * 16'(k + 1) + 16'(k), 1'b0);
    idle(3);
    send_pkt(8'h60, 8'hF0, 16'hCAFE, 1'b0);
    step(3'b000, 8'h00, 1'b1, 1'b0);   // pop in the same cycle as the full commit
    idle(2);
    cur_req = "R4";
    for (int k = 0; k < 5; k++) step(3'b000, 8'h00, 1'b1, 1'b0);
    idle(2);
    cur_req = "R8";
    step(3'b000, 8'h00, 1'b0, 1'b1);
    idle(2);
    cur_req = "R3";
    send_pkt(8'h70, 8'h07, 16'hFFFF, 1'b0);
    idle(2);
    step(3'b000, 8'h00, 1'b1, 1'b0);
    idle(3);

    @(negedge clk);
    compare_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule